// File: doc/BRIEF.md
# Break-Even Sleep Decision Controller

This block decides when one subsystem should be switched off during an idle gap. The subsystem has two modes only, on and off. Dropping from on to off costs nothing beyond the drain time. Coming back from off costs a surge of extra power and a wake-up delay. The controller switches off only when a policy says it pays, then drives the power-enable and ready outputs through a timed shutdown and a timed wake-up.

A two-bit policy input selects one of four rules:
- Never switch off.
- Switch off as soon as the subsystem goes idle.
- Switch off when a supplied idle-gap prediction reaches the break-even length.
- Switch off once the real idle time has run past the break-even length.

The break-even length is fixed at elaboration, in clock cycles, from the per-state power parameters and the wake-up length. An energy accumulator adds the power of the current state on every clock. A bench can compare the energy each policy spends with the latency it adds.

A task request (`taskReq`, active high, level) keeps the subsystem on. It aborts a shutdown that is in progress, and it starts a wake-up from off. `ready` shows when work can be accepted again.

Top module: `breakeven_sleep_ctrl`

## Requirements
- R1: During and right after reset the controller is in the on state: `pwrState` = 0, `ready` = 1, `pwrEn` = 1 and `energyAcc` = 0. State codes are on = 0, shutdown = 1, off = 2, wake = 3.
- R2: In the on state with `taskReq` high, the state stays on under every policy.
- R3: With policy 0 (always-on) the on state is never left, whatever the idle time.
- R4: With policy 1 (greedy), an on cycle with `taskReq` low moves to shutdown at the next edge.
- R5: Shutdown lasts SHUT_CYC cycles (default 1) and then enters off. `pwrEn` is low only in off, and `ready` is high only in on.
- R6: In off, a high `taskReq` moves to wake at the next edge. Wake lasts WAKE_CYC cycles (default 2) and then returns to on; `taskReq` is ignored during wake.
- R7: A high `taskReq` during shutdown aborts it, and wake starts at the next edge.
- R8: The break-even length is BE = max(0, ceil((WAKE_PWR − ON_PWR)·WAKE_CYC / (ON_PWR − OFF_PWR))). With the defaults ON_PWR=10, OFF_PWR=0, WAKE_PWR=40 and WAKE_CYC=2, this gives BE = 6.
- R9: With policy 2 (predicted), an on cycle with `taskReq` low, `predValid` high and `predGap` ≥ BE moves to shutdown. A smaller gap, or `predValid` low, leaves the state on.
- R10: With policy 3 (timeout), shutdown is entered at the edge that ends the (BE+1)-th consecutive idle on cycle. A high `taskReq` restarts the count.
- R11: At every edge `energyAcc` grows by the power of the state held before that edge: ON_PWR=10 for on, SHUT_PWR=10 for shutdown, OFF_PWR=0 for off and WAKE_PWR=40 for wake.
- R12: Off is held for as long as `taskReq` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| policyMode | input | 2 | 0 always-on, 1 greedy, 2 predicted, 3 timeout |
| taskReq | input | 1 | Work pending; wake request |
| predValid | input | 1 | `predGap` carries a new idle prediction |
| predGap | input | GAP_W | Predicted idle length in cycles |
| pwrEn | output | 1 | Supply enable for the subsystem |
| ready | output | 1 | Subsystem can accept work |
| pwrState | output | 2 | Current state code |
| energyAcc | output | ENERGY_W | Accumulated per-cycle power |

## Verification
Each policy is driven with the same idle stretch, and the results are compared:
- Always-on keeps the state on and its energy grows linearly.
- Greedy spends a fixed 100 units over a full off/on round trip, whatever the off length.

Predictions of 5, 6 and 100 cycles, with and without pending work, separate the boundary at BE from the busy override. Timeout runs of 6, 7 and interrupted idle cycles pin the counter boundary and its restart. A request placed inside shutdown, and a request dropped inside wake, separate abort from a normal wake-up.

// File: rtl/sleep_pkg.sv
package sleep_pkg;

  typedef enum logic [1:0] {
    ST_ON   = 2'd0,
    ST_SHUT = 2'd1,
    ST_OFF  = 2'd2,
    ST_WAKE = 2'd3
  } pwr_state_e;

  typedef enum logic [1:0] {
    POL_ALWAYS  = 2'd0,
    POL_GREEDY  = 2'd1,
    POL_PREDICT = 2'd2,
    POL_TIMEOUT = 2'd3
  } policy_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic       seqClr;
    logic       seqInc;
    logic       idleClr;
    logic       idleInc;
    pwr_state_e curState;
  } dp_strobe_t;

endpackage

// File: rtl/sleep_datapath.sv
module sleep_datapath
  import sleep_pkg::*;
#(
  parameter int SEQ_W    = 2,
  parameter int IDLE_W   = 3,
  parameter int IDLE_MAX = 6,
  parameter int ENERGY_W = 32,
  parameter int ON_PWR   = 10,
  parameter int OFF_PWR  = 0,
  parameter int SHUT_PWR = 10,
  parameter int WAKE_PWR = 40
) (
  input  logic                clk,
  input  logic                rstN,
  input  dp_strobe_t          strobe,
  output logic [SEQ_W-1:0]    seqCnt,
  output logic [IDLE_W-1:0]   idleCnt,
  output logic [ENERGY_W-1:0] energyAcc
);

  localparam logic [ENERGY_W-1:0] E_ON   = ENERGY_W'(ON_PWR);
  localparam logic [ENERGY_W-1:0] E_OFF  = ENERGY_W'(OFF_PWR);
  localparam logic [ENERGY_W-1:0] E_SHUT = ENERGY_W'(SHUT_PWR);
  localparam logic [ENERGY_W-1:0] E_WAKE = ENERGY_W'(WAKE_PWR);
  localparam logic [IDLE_W-1:0]   I_MAX  = IDLE_W'(IDLE_MAX);

  logic [ENERGY_W-1:0] stepPwr;

  always_comb begin
    unique case (strobe.curState)
      ST_ON:   stepPwr = E_ON;
      ST_SHUT: stepPwr = E_SHUT;
      ST_OFF:  stepPwr = E_OFF;
      default: stepPwr = E_WAKE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seqCnt    <= '0;
      idleCnt   <= '0;
      energyAcc <= '0;
    end else begin
      energyAcc <= energyAcc + stepPwr;
      if (strobe.seqClr)      seqCnt <= '0;
      else if (strobe.seqInc) seqCnt <= seqCnt + 1'b1;
      if (strobe.idleClr)     idleCnt <= '0;
      else if (strobe.idleInc && idleCnt < I_MAX) idleCnt <= idleCnt + 1'b1;
    end
  end

endmodule

// File: rtl/sleep_ctrl.sv
module sleep_ctrl
  import sleep_pkg::*;
#(
  parameter int SEQ_W      = 2,
  parameter int IDLE_W     = 3,
  parameter int GAP_W      = 16,
  parameter int SHUT_CYC   = 1,
  parameter int WAKE_CYC   = 2,
  parameter int BREAK_EVEN = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        policyMode,
  input  logic              taskReq,
  input  logic              predValid,
  input  logic [GAP_W-1:0]  predGap,
  input  logic [SEQ_W-1:0]  seqCnt,
  input  logic [IDLE_W-1:0] idleCnt,
  output dp_strobe_t        strobe,
  output pwr_state_e        state
);

  pwr_state_e nextState;
  logic       shutGo;
  logic       shutDone;
  logic       wakeDone;

  assign shutDone = (int'(seqCnt) >= SHUT_CYC - 1);
  assign wakeDone = (int'(seqCnt) >= WAKE_CYC - 1);

  always_comb begin
    unique case (policy_e'(policyMode))
      POL_ALWAYS:  shutGo = 1'b0;
      POL_GREEDY:  shutGo = !taskReq;
      POL_PREDICT: shutGo = !taskReq && predValid && (int'(predGap) >= BREAK_EVEN);
      default:     shutGo = !taskReq && (int'(idleCnt) >= BREAK_EVEN);
    endcase
  end

  always_comb begin
    nextState       = state;
    strobe.seqClr   = 1'b0;
    strobe.seqInc   = 1'b0;
    strobe.idleClr  = 1'b1;
    strobe.idleInc  = 1'b0;
    strobe.curState = state;
    unique case (state)
      ST_ON: begin
        if (!taskReq) begin
          strobe.idleClr = 1'b0;
          strobe.idleInc = 1'b1;
        end
        if (shutGo) begin
          nextState     = ST_SHUT;
          strobe.seqClr = 1'b1;
        end
      end
      ST_SHUT: begin
        if (taskReq) begin
          nextState     = ST_WAKE;
          strobe.seqClr = 1'b1;
        end else if (shutDone) begin
          nextState = ST_OFF;
        end else begin
          strobe.seqInc = 1'b1;
        end
      end
      ST_OFF: begin
        if (taskReq) begin
          nextState     = ST_WAKE;
          strobe.seqClr = 1'b1;
        end
      end
      default: begin
        if (wakeDone) nextState = ST_ON;
        else          strobe.seqInc = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_ON;
    else       state <= nextState;
  end

endmodule

// File: rtl/breakeven_sleep_ctrl.sv
module breakeven_sleep_ctrl
  import sleep_pkg::*;
#(
  parameter int GAP_W    = 16,
  parameter int ENERGY_W = 32,
  parameter int ON_PWR   = 10,
  parameter int OFF_PWR  = 0,
  parameter int SHUT_PWR = 10,
  parameter int WAKE_PWR = 40,
  parameter int SHUT_CYC = 1,
  parameter int WAKE_CYC = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          policyMode,
  input  logic                taskReq,
  input  logic                predValid,
  input  logic [GAP_W-1:0]    predGap,
  output logic                pwrEn,
  output logic                ready,
  output logic [1:0]          pwrState,
  output logic [ENERGY_W-1:0] energyAcc
);

  localparam int NUM        = (WAKE_PWR - ON_PWR) * WAKE_CYC;
  localparam int DEN        = ON_PWR - OFF_PWR;
  localparam int BREAK_EVEN = (NUM <= 0) ? 0 : (NUM + DEN - 1) / DEN;
  localparam int MAX_SEQ    = (SHUT_CYC > WAKE_CYC) ? SHUT_CYC : WAKE_CYC;
  localparam int SEQ_W      = $clog2(MAX_SEQ + 1);
  localparam int IDLE_W     = $clog2(BREAK_EVEN + 2);

  dp_strobe_t        strobe;
  pwr_state_e        state;
  logic [SEQ_W-1:0]  seqCnt;
  logic [IDLE_W-1:0] idleCnt;

  sleep_ctrl #(
    .SEQ_W(SEQ_W), .IDLE_W(IDLE_W), .GAP_W(GAP_W),
    .SHUT_CYC(SHUT_CYC), .WAKE_CYC(WAKE_CYC), .BREAK_EVEN(BREAK_EVEN)
  ) ctrlInst (
    .clk(clk), .rstN(rstN), .policyMode(policyMode), .taskReq(taskReq),
    .predValid(predValid), .predGap(predGap), .seqCnt(seqCnt),
    .idleCnt(idleCnt), .strobe(strobe), .state(state)
  );

  sleep_datapath #(
    .SEQ_W(SEQ_W), .IDLE_W(IDLE_W), .IDLE_MAX(BREAK_EVEN), .ENERGY_W(ENERGY_W),
    .ON_PWR(ON_PWR), .OFF_PWR(OFF_PWR), .SHUT_PWR(SHUT_PWR), .WAKE_PWR(WAKE_PWR)
  ) dpInst (
    .clk(clk), .rstN(rstN), .strobe(strobe), .seqCnt(seqCnt),
    .idleCnt(idleCnt), .energyAcc(energyAcc)
  );

  assign pwrEn    = (state != ST_OFF);
  assign ready    = (state == ST_ON);
  assign pwrState = state;

endmodule

// File: rtl/breakeven_sleep_ctrl_chk.sv
module breakeven_sleep_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] policyMode,
  input logic       taskReq,
  input logic       pwrEn,
  input logic       ready,
  input logic [1:0] pwrState
);

  assert_ready_powered_R5: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> pwrEn);

  assert_busy_holds_R2: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 2'd0 && taskReq) |=> (pwrState == 2'd0));

  assert_always_on_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 2'd0 && policyMode == 2'd0) |=> (pwrState == 2'd0));

  assert_greedy_sleep_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 2'd0 && policyMode == 2'd1 && !taskReq) |=> (pwrState == 2'd1));

  assert_off_wakes_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 2'd2 && taskReq) |=> (pwrState == 2'd3));

  assert_shut_abort_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 2'd1 && taskReq) |=> (pwrState == 2'd3));

  assert_off_holds_R12: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 2'd2 && !taskReq) |=> (pwrState == 2'd2));

endmodule

bind breakeven_sleep_ctrl breakeven_sleep_ctrl_chk chkInst (
  .clk(clk), .rstN(rstN), .policyMode(policyMode), .taskReq(taskReq),
  .pwrEn(pwrEn), .ready(ready), .pwrState(pwrState)
);

// File: tb/tb_breakeven_sleep_ctrl.sv
module tb_breakeven_sleep_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int GAP_W      = 16;
  localparam int ENERGY_W   = 32;
  localparam int P_ON = 10, P_OFF = 0, P_SHUT = 10, P_WAKE = 40;
  localparam int C_WAKE = 2;
  localparam int BE_EXP = ((P_WAKE - P_ON) * C_WAKE + (P_ON - P_OFF) - 1) / (P_ON - P_OFF);

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic [1:0]          policyMode = 2'd0;
  logic                taskReq = 1'b1;
  logic                predValid = 1'b0;
  logic [GAP_W-1:0]    predGap = '0;
  logic                pwrEn;
  logic                ready;
  logic [1:0]          pwrState;
  logic [ENERGY_W-1:0] energyAcc;

  int vectors = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  breakeven_sleep_ctrl dut (
    .clk(clk), .rstN(rstN), .policyMode(policyMode), .taskReq(taskReq),
    .predValid(predValid), .predGap(predGap), .pwrEn(pwrEn), .ready(ready),
    .pwrState(pwrState), .energyAcc(energyAcc)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bringUp();
    taskReq = 1'b1;
    predValid = 1'b0;
    for (int i = 0; i < 10; i++) begin
      if (pwrState == 2'd0) break;
      step(1);
    end
  endtask

  task automatic testReset();
    step(2);
    chk("R1 state", pwrState, 0);
    chk("R1 ready", ready, 1);
    chk("R1 pwrEn", pwrEn, 1);
    chk("R1 energy", energyAcc, 0);
    rstN = 1'b1;
    step(1);
    chk("R1 state after release", pwrState, 0);
  endtask

  task automatic testAlwaysOn();
    longint e0;
    bringUp();
    policyMode = 2'd0;
    e0 = energyAcc;
    taskReq = 1'b0;
    step(20);
    chk("R3 always-on state", pwrState, 0);
    chk("R11 always-on energy", energyAcc - e0, 20 * P_ON);
  endtask

  task automatic testBusy();
    bringUp();
    policyMode = 2'd1;
    step(5);
    chk("R2 busy greedy stays on", pwrState, 0);
    policyMode = 2'd3;
    step(BE_EXP + 3);
    chk("R2 busy timeout stays on", pwrState, 0);
  endtask

  task automatic testGreedy();
    longint e0;
    bringUp();
    policyMode = 2'd1;
    e0 = energyAcc;
    taskReq = 1'b0;
    step(1);
    chk("R4 greedy enters shutdown", pwrState, 1);
    chk("R5 ready low in shutdown", ready, 0);
    chk("R5 pwrEn high in shutdown", pwrEn, 1);
    step(1);
    chk("R5 off after shutdown", pwrState, 2);
    chk("R5 pwrEn low in off", pwrEn, 0);
    step(5);
    chk("R12 off held", pwrState, 2);
    chk("R11 off adds nothing", energyAcc - e0, 2 * P_ON);
    taskReq = 1'b1;
    step(1);
    chk("R6 wake entered", pwrState, 3);
    chk("R6 pwrEn in wake", pwrEn, 1);
    chk("R6 ready low in wake", ready, 0);
    taskReq = 1'b0;
    step(1);
    chk("R6 wake ignores drop", pwrState, 3);
    step(1);
    chk("R6 back on after wake", pwrState, 0);
    chk("R6 ready after wake", ready, 1);
    chk("R11 greedy round trip energy", energyAcc - e0, P_ON + P_SHUT + C_WAKE * P_WAKE);
    taskReq = 1'b1;
  endtask

  task automatic testAbort();
    bringUp();
    policyMode = 2'd1;
    taskReq = 1'b0;
    step(1);
    chk("R7 shutdown begun", pwrState, 1);
    taskReq = 1'b1;
    step(1);
    chk("R7 abort goes to wake", pwrState, 3);
    step(2);
    chk("R7 on after aborted shutdown", pwrState, 0);
  endtask

  task automatic testPredict();
    bringUp();
    policyMode = 2'd2;
    taskReq = 1'b0;
    step(3);
    chk("R9 no prediction stays on", pwrState, 0);
    predValid = 1'b1;
    predGap = GAP_W'(BE_EXP - 1);
    step(1);
    chk("R9 gap below BE stays on", pwrState, 0);
    taskReq = 1'b1;
    predGap = 16'd100;
    step(1);
    chk("R9 busy ignores long gap", pwrState, 0);
    taskReq = 1'b0;
    predGap = GAP_W'(BE_EXP);
    step(1);
    chk("R8 R9 gap equal BE shuts down", pwrState, 1);
    predValid = 1'b0;
  endtask

  task automatic testTimeout();
    bringUp();
    policyMode = 2'd3;
    taskReq = 1'b0;
    step(BE_EXP);
    chk("R10 on after BE idle cycles", pwrState, 0);
    step(1);
    chk("R8 R10 shutdown after BE+1 idle cycles", pwrState, 1);
    bringUp();
    taskReq = 1'b0;
    step(4);
    taskReq = 1'b1;
    step(1);
    taskReq = 1'b0;
    step(BE_EXP);
    chk("R10 restart after task", pwrState, 0);
    step(1);
    chk("R10 shutdown after restart", pwrState, 1);
  endtask

  initial begin
    testReset();
    testAlwaysOn();
    testBusy();
    testGreedy();
    testAbort();
    testPredict();
    testTimeout();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      vectors++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule